// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a DDR2 SDRAM from power-up to a usable state. It waits for the memory controller to request a start. It then holds the clock enable low for the power-up interval, raises it, and issues the standard DDR2 bring-up commands. It programs the mode register and the extended mode registers from compile-time parameters: CAS latency, additive latency, write recovery, burst type, nominal termination, drive strength and strobe mode. After that it opens row 0 of bank 0 and runs a fixed calibration pattern of three BL8 reads. It closes the row and reports completion on a status pin.

The command bus (clock enable, chip select, row strobe, column strobe, write enable, bank and address) is driven from registers at the memory command rate. The spacing between commands comes from picosecond timing parameters divided by the clock period and rounded up. A simulation flag shortens the two long waits, power-up and DLL lock, so that a testbench finishes quickly. A bypass flag skips the sequence entirely, leaving initialization to the controller.

Only plain control and status pins exist: no data moves through the block, so no handshake or back-pressure applies.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset and until a start is sampled, clock enable is low, the command pins carry NOP (chip select 0, row strobe 1, column strobe 1, write enable 1) and the completion output is low; no other command appears while clock enable is low.
- R2: The start input is sampled on a clock edge while idle. Clock enable rises exactly PWRUP cycles after that edge and stays high. The first precharge-all follows exactly ceil(400000 ps / tCK) cycles after the rise.
- R3: Exactly 16 commands are issued, in this order: precharge-all, load EMR2, load EMR3, load EMR1, load MR with DLL reset, precharge-all, refresh, refresh, load MR, load EMR1 with OCD default, load EMR1 with OCD exit, activate, read, read, read, precharge-all.
- R4: The command encodings as {chip select, row strobe, column strobe, write enable} are: precharge 0010 with address bit 10 high and all other address bits low, refresh 0001, mode load 0000, activate 0011, read 0101.
- R5: A mode register load carries bank 0. Its address bits are: [2:0]=011 (burst length 8), [3]=0 for sequential and 1 for interleaved burst, [6:4]=CAS latency, [8]=DLL reset (1 only in the first load), [11:9]=write recovery minus 1, and all other bits 0.
- R6: An EMR1 load carries bank 1. Its address bits are: [0]=0 (DLL enabled), [1]=1 for reduced drive, {[6],[2]} = 01 for 75 ohm, 10 for 150 ohm and 11 for 50 ohm, [5:3]=additive latency, [9:7]=111 for the OCD-default load and 000 otherwise, [10]=1 when single-ended strobes are chosen, and all other bits 0.
- R7: The EMR2 load uses bank 2 and the EMR3 load uses bank 3, each with an all-zero address.
- R8: Command-to-command spacing is exact. Precharge-all is followed by ceil(tRPA/tCK) cycles, refresh by ceil(tRFC/tCK), activate by ceil(tRCD/tCK), and each mode load by 2 cycles; every such count is at least 2. The last EMR1 load is followed by the DLL lock wait.
- R9: Calibration opens bank 0 row 0 and reads column 0 of bank 0 with address bit 10 low. The second read comes 4 cycles after the first, and the third 8 cycles after the second (same phase of a 4-cycle frame). The closing precharge-all follows the third read by CL+AL+4 cycles.
- R10: Completion rises exactly ceil(tRPA/tCK) cycles after the closing precharge-all. It then stays high until reset, and the bus carries only NOP.
- R11: Start is only looked at while idle: dropping it during the sequence, or holding it after completion, changes nothing.
- R12: With the bypass flag set, completion rises on the same edge that samples start, no command is issued and clock enable stays low.
- R13: With the simulation flag set, the power-up wait and the DLL lock wait are each SIM_WAIT cycles; otherwise they are ceil(POWERUP_PS/tCK) and DLL_LOCK_CYC cycles.
- R14: Reset asserted at any point returns every output to the R1 state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_start_i | input | 1 | Start request from the controller, level sampled while idle |
| init_complete_o | output | 1 | Initialization and calibration done |
| cke_o | output | 1 | Clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Row/column/mode address |

## Verification
Several properties are checked on every cycle: the bus stays at NOP while clock enable is low and after completion, clock enable and completion never fall without a reset, and no two commands are ever adjacent. Only the bench scenarios can show the exact order of the sixteen commands, the mode-register bit patterns for two different parameter sets, and the exact spacing counts derived from the picosecond values. The same holds for the bypass shortcut, the indifference to the start level once running, and recovery from a reset in mid-sequence.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [2:0] {
    C_NOP, C_PREA, C_REF, C_MRS, C_ACT, C_READ
  } cmd_e;

  typedef struct packed {
    cmd_e        cmd;
    logic [1:0]  ba;
    logic [12:0] a;
  } cmd_t;

  localparam cmd_t NOP_CMD = '{cmd: C_NOP, ba: 2'b00, a: 13'b0};

  typedef enum logic [4:0] {
    ST_CKE, ST_PRE1, ST_EMR2, ST_EMR3, ST_EMR1, ST_MR_DLL, ST_PRE2,
    ST_REF1, ST_REF2, ST_MR, ST_OCD_DFLT, ST_OCD_EXIT, ST_ACT,
    ST_RD1, ST_RD2, ST_RD3, ST_PRE3, ST_DONE
  } step_e;

  // Rounded-up conversion of a picosecond interval, never below 2 cycles.
  function automatic int ps_to_cyc(input int t_ps, input int tck_ps);
    int c;
    c = (t_ps + tck_ps - 1) / tck_ps;
    return (c < 2) ? 2 : c;
  endfunction

  function automatic logic [12:0] mr_word(input int cl, input int wr,
                                          input bit seq, input bit dll_rst);
    logic [12:0] w;
    w = '0;
    w[2:0]  = 3'b011;
    w[3]    = ~seq;
    w[6:4]  = 3'(cl);
    w[8]    = dll_rst;
    w[11:9] = 3'(wr - 1);
    return w;
  endfunction

  function automatic logic [12:0] emr1_word(input int al, input int rtt,
                                            input bit full, input bit diff,
                                            input bit ocd_dflt);
    logic [12:0] w;
    w = '0;
    w[1]   = ~full;
    w[2]   = (rtt == 75) || (rtt == 50);
    w[6]   = (rtt == 150) || (rtt == 50);
    w[5:3] = 3'(al);
    w[9:7] = ocd_dflt ? 3'b111 : 3'b000;
    w[10]  = ~diff;
    return w;
  endfunction

endpackage

// File: rtl/ddr2_wait_timer.sv
module ddr2_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr2_cmd_drive.sv
module ddr2_cmd_drive import ddr2_init_pkg::*; #(
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_t              cmd_i,
  input  logic              cke_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [3:0]        pins_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = ADDR_W'(cmd_i.a);
    unique case (cmd_i.cmd)
      C_PREA: begin pins_d = 4'b0010; addr_d[10] = 1'b1; end
      C_REF:  pins_d = 4'b0001;
      C_MRS:  pins_d = 4'b0000;
      C_ACT:  pins_d = 4'b0011;
      C_READ: begin pins_d = 4'b0101; addr_d[10] = 1'b0; end
      default: pins_d = 4'b0111;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_o <= 1'b0;
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= 4'b0111;
      ba_o   <= '0;
      addr_o <= '0;
    end else begin
      cke_o <= cke_i;
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= pins_d;
      ba_o   <= BA_W'(cmd_i.ba);
      addr_o <= addr_d;
    end
  end
endmodule

// File: rtl/ddr2_step_table.sv
module ddr2_step_table import ddr2_init_pkg::*; #(
  parameter int WAIT_W     = 16,
  parameter int CAS_LAT    = 5,
  parameter int ADD_LAT    = 0,
  parameter int WR_CYC     = 2,
  parameter bit SEQ_BURST  = 1'b1,
  parameter int RTT_OHM    = 75,
  parameter bit FULL_DRIVE = 1'b1,
  parameter bit DIFF_DQS   = 1'b1,
  parameter int XPR_CYC    = 50,
  parameter int RPA_CYC    = 4,
  parameter int RFC_CYC    = 41,
  parameter int RCD_CYC    = 3,
  parameter int MRD_CYC    = 2,
  parameter int LOCK_CYC   = 200,
  parameter int DRAIN_CYC  = 9
) (
  input  step_e             step_i,
  output cmd_t              cmd_o,
  output logic [WAIT_W-1:0] gap_o
);
  localparam logic [12:0] MR_RST   = mr_word(CAS_LAT, WR_CYC, SEQ_BURST, 1'b1);
  localparam logic [12:0] MR_RUN   = mr_word(CAS_LAT, WR_CYC, SEQ_BURST, 1'b0);
  localparam logic [12:0] EMR_RUN  = emr1_word(ADD_LAT, RTT_OHM, FULL_DRIVE, DIFF_DQS, 1'b0);
  localparam logic [12:0] EMR_DFLT = emr1_word(ADD_LAT, RTT_OHM, FULL_DRIVE, DIFF_DQS, 1'b1);

  always_comb begin
    cmd_o = NOP_CMD;
    gap_o = WAIT_W'(1);
    unique case (step_i)
      ST_CKE:      gap_o = WAIT_W'(XPR_CYC);
      ST_PRE1,
      ST_PRE2,
      ST_PRE3:     begin cmd_o.cmd = C_PREA; gap_o = WAIT_W'(RPA_CYC); end
      ST_EMR2:     begin cmd_o = '{cmd: C_MRS, ba: 2'd2, a: 13'b0}; gap_o = WAIT_W'(MRD_CYC); end
      ST_EMR3:     begin cmd_o = '{cmd: C_MRS, ba: 2'd3, a: 13'b0}; gap_o = WAIT_W'(MRD_CYC); end
      ST_EMR1:     begin cmd_o = '{cmd: C_MRS, ba: 2'd1, a: EMR_RUN}; gap_o = WAIT_W'(MRD_CYC); end
      ST_MR_DLL:   begin cmd_o = '{cmd: C_MRS, ba: 2'd0, a: MR_RST}; gap_o = WAIT_W'(MRD_CYC); end
      ST_REF1,
      ST_REF2:     begin cmd_o.cmd = C_REF; gap_o = WAIT_W'(RFC_CYC); end
      ST_MR:       begin cmd_o = '{cmd: C_MRS, ba: 2'd0, a: MR_RUN}; gap_o = WAIT_W'(MRD_CYC); end
      ST_OCD_DFLT: begin cmd_o = '{cmd: C_MRS, ba: 2'd1, a: EMR_DFLT}; gap_o = WAIT_W'(MRD_CYC); end
      ST_OCD_EXIT: begin cmd_o = '{cmd: C_MRS, ba: 2'd1, a: EMR_RUN}; gap_o = WAIT_W'(LOCK_CYC); end
      ST_ACT:      begin cmd_o.cmd = C_ACT; gap_o = WAIT_W'(RCD_CYC); end
      ST_RD1:      begin cmd_o.cmd = C_READ; gap_o = WAIT_W'(4); end
      ST_RD2:      begin cmd_o.cmd = C_READ; gap_o = WAIT_W'(8); end
      ST_RD3:      begin cmd_o.cmd = C_READ; gap_o = WAIT_W'(DRAIN_CYC); end
      default:     gap_o = WAIT_W'(1);
    endcase
  end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq import ddr2_init_pkg::*; #(
  parameter int TCK_PS       = 8000,
  parameter int TRPA_PS      = 25000,
  parameter int TRFC_PS      = 327000,
  parameter int TRCD_PS      = 20000,
  parameter int TXPR_PS      = 400000,
  parameter int POWERUP_PS   = 200000000,
  parameter int TMRD_CYC     = 2,
  parameter int DLL_LOCK_CYC = 200,
  parameter int CAS_LAT      = 5,
  parameter int ADD_LAT      = 0,
  parameter int WR_CYC       = 2,
  parameter bit SEQ_BURST    = 1'b1,
  parameter int RTT_OHM      = 75,
  parameter bit FULL_DRIVE   = 1'b1,
  parameter bit DIFF_DQS     = 1'b1,
  parameter bit SIM_MODE     = 1'b0,
  parameter int SIM_WAIT     = 16,
  parameter bit BYPASS       = 1'b0,
  parameter int ADDR_W       = 14,
  parameter int BA_W         = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_start_i,
  output logic              init_complete_o,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int PWRUP_CYC = SIM_MODE ? SIM_WAIT : ps_to_cyc(POWERUP_PS, TCK_PS);
  localparam int LOCK_CYC  = SIM_MODE ? SIM_WAIT : DLL_LOCK_CYC;
  localparam int XPR_CYC   = ps_to_cyc(TXPR_PS, TCK_PS);
  localparam int RPA_CYC   = ps_to_cyc(TRPA_PS, TCK_PS);
  localparam int RFC_CYC   = ps_to_cyc(TRFC_PS, TCK_PS);
  localparam int RCD_CYC   = ps_to_cyc(TRCD_PS, TCK_PS);
  localparam int MRD_CYC   = (TMRD_CYC < 2) ? 2 : TMRD_CYC;
  localparam int DRAIN_CYC = CAS_LAT + ADD_LAT + 4;
  localparam int WAIT_W    = $clog2(PWRUP_CYC + LOCK_CYC + XPR_CYC + RPA_CYC + RFC_CYC
                                    + RCD_CYC + MRD_CYC + DRAIN_CYC) + 1;

  step_e             step_q;
  logic              busy_q, done_q, cke_q;
  logic              tmr_zero, tmr_load, issue, start_go;
  logic [WAIT_W-1:0] tmr_val, step_gap;
  cmd_t              step_cmd, bus_cmd;

  assign start_go = !busy_q && !done_q && init_start_i;
  assign issue    = busy_q && tmr_zero;
  assign tmr_load = (start_go && !BYPASS) || issue;
  assign tmr_val  = start_go ? WAIT_W'(PWRUP_CYC - 1) : (step_gap - WAIT_W'(1));
  assign bus_cmd  = issue ? step_cmd : NOP_CMD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cke_q  <= 1'b0;
      step_q <= ST_CKE;
    end else if (start_go) begin
      if (BYPASS) begin
        done_q <= 1'b1;
      end else begin
        busy_q <= 1'b1;
        step_q <= ST_CKE;
      end
    end else if (issue) begin
      if (step_q == ST_CKE) cke_q <= 1'b1;
      if (step_q == ST_DONE) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        step_q <= step_e'(step_q + 1'b1);
      end
    end
  end

  assign init_complete_o = done_q;

  ddr2_wait_timer #(.W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  ddr2_step_table #(
    .WAIT_W(WAIT_W), .CAS_LAT(CAS_LAT), .ADD_LAT(ADD_LAT), .WR_CYC(WR_CYC),
    .SEQ_BURST(SEQ_BURST), .RTT_OHM(RTT_OHM), .FULL_DRIVE(FULL_DRIVE), .DIFF_DQS(DIFF_DQS),
    .XPR_CYC(XPR_CYC), .RPA_CYC(RPA_CYC), .RFC_CYC(RFC_CYC), .RCD_CYC(RCD_CYC),
    .MRD_CYC(MRD_CYC), .LOCK_CYC(LOCK_CYC), .DRAIN_CYC(DRAIN_CYC)
  ) u_table (
    .step_i(step_q), .cmd_o(step_cmd), .gap_o(step_gap)
  );

  ddr2_cmd_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .cmd_i(bus_cmd), .cke_i(cke_q || (issue && step_q == ST_CKE)),
    .cke_o(cke_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .ba_o(ba_o), .addr_o(addr_o)
  );
endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic done
);
  logic is_nop;
  assign is_nop = !cs_n && ras_n && cas_n && we_n;

  assert_nop_while_cke_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> is_nop);

  assert_cke_stays_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  assert_commands_never_adjacent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |=> is_nop);

  assert_complete_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_quiet_after_complete_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> is_nop);
endmodule

bind ddr2_init_seq ddr2_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke_o), .cs_n(cs_n_o), .ras_n(ras_n_o),
  .cas_n(cas_n_o), .we_n(we_n_o), .done(init_complete_o)
);

// File: tb/ddr2_init_seq_tb_top.sv
module ddr2_init_seq_mon #(
  parameter int    TCK_PS     = 8000,
  parameter int    CAS_LAT    = 5,
  parameter int    ADD_LAT    = 0,
  parameter int    WR_CYC     = 2,
  parameter bit    SEQ_BURST  = 1'b1,
  parameter int    RTT_OHM    = 75,
  parameter bit    FULL_DRIVE = 1'b1,
  parameter bit    DIFF_DQS   = 1'b1,
  parameter int    SIM_WAIT   = 16,
  parameter string NAME       = "a"
) (
  input logic        clk,
  input logic        clr,
  input int          cyc,
  input logic        cke,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [2:0]  ba,
  input logic [13:0] addr,
  input logic        done
);
  int n, cke_rise, done_rise, low_cmds;
  int checks = 0;
  int fails = 0;
  logic [3:0]  pins [32];
  logic [2:0]  bas  [32];
  logic [13:0] adrs [32];
  int          cycs [32];

  function automatic int cdiv(input int ps);
    int c;
    c = (ps + TCK_PS - 1) / TCK_PS;
    if (c < 2) c = 2;
    return c;
  endfunction

  function automatic logic [13:0] b_mr(input bit dll);
    logic [13:0] w;
    w = '0;
    w[1:0] = 2'b11;
    w[3] = SEQ_BURST ? 1'b0 : 1'b1;
    w[6:4] = 3'(CAS_LAT);
    w[8] = dll;
    w[11:9] = 3'(WR_CYC - 1);
    return w;
  endfunction

  function automatic logic [13:0] b_emr1(input bit ocd);
    logic [13:0] w;
    w = '0;
    if (!FULL_DRIVE) w[1] = 1'b1;
    if (RTT_OHM == 50)  begin w[6] = 1'b1; w[2] = 1'b1; end
    if (RTT_OHM == 75)  w[2] = 1'b1;
    if (RTT_OHM == 150) w[6] = 1'b1;
    w[5:3] = 3'(ADD_LAT);
    if (ocd) w[9:7] = 3'b111;
    if (!DIFF_DQS) w[10] = 1'b1;
    return w;
  endfunction

  function automatic logic [3:0] exp_pins(input int i);
    case (i)
      0, 5, 15:        return 4'b0010;
      6, 7:            return 4'b0001;
      11:              return 4'b0011;
      12, 13, 14:      return 4'b0101;
      default:         return 4'b0000;
    endcase
  endfunction

  function automatic logic [2:0] exp_ba(input int i);
    case (i)
      1: return 3'd2;
      2: return 3'd3;
      3, 9, 10: return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [13:0] exp_addr(input int i);
    case (i)
      0, 5, 15: return 14'h0400;
      3, 10:    return b_emr1(1'b0);
      9:        return b_emr1(1'b1);
      4:        return b_mr(1'b1);
      8:        return b_mr(1'b0);
      default:  return 14'h0000;
    endcase
  endfunction

  function automatic int exp_gap(input int i);
    case (i)
      0, 5:  return cdiv(25000);
      6, 7:  return cdiv(327000);
      10:    return SIM_WAIT;
      11:    return cdiv(20000);
      12:    return 4;
      13:    return 8;
      14:    return CAS_LAT + ADD_LAT + 4;
      default: return 2;
    endcase
  endfunction

  function automatic string tag(input int i);
    case (i)
      1, 2:      return "R7";
      3, 9, 10:  return "R6";
      4, 8:      return "R5";
      11, 12, 13, 14: return "R9";
      default:   return "R4";
    endcase
  endfunction

  always @(negedge clk) begin
    if (clr) begin
      n = 0; cke_rise = -1; done_rise = -1; low_cmds = 0;
    end else begin
      if (cke && cke_rise < 0) cke_rise = cyc;
      if (done && done_rise < 0) done_rise = cyc;
      if (!(cs_n == 1'b0 && ras_n && cas_n && we_n)) begin
        if (!cke) low_cmds++;
        if (n < 32) begin
          pins[n] = {cs_n, ras_n, cas_n, we_n};
          bas[n] = ba; adrs[n] = addr; cycs[n] = cyc;
        end
        n++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL dut_%s %s %s: actual=%0d expected=%0d", NAME, req, what, act, expv);
    end
  endtask

  task automatic verify_idle();
    chk(n == 0, "R1", "commands before start", n, 0);
    chk(cke_rise < 0 && done_rise < 0, "R1", "cke/complete before start", cke_rise, -1);
  endtask

  task automatic verify(input int se, input bit bypass);
    if (bypass) begin
      chk(n == 0, "R12", "commands in bypass", n, 0);
      chk(cke_rise < 0, "R12", "cke rise in bypass", cke_rise, -1);
      chk(done_rise == se, "R12", "complete edge in bypass", done_rise, se);
      return;
    end
    chk(low_cmds == 0, "R1", "commands while cke low", low_cmds, 0);
    chk(n == 16, "R3", "command count", n, 16);
    chk(cke_rise - se == SIM_WAIT, "R2/R13", "power-up wait", cke_rise - se, SIM_WAIT);
    if (n >= 1)
      chk(cycs[0] - cke_rise == cdiv(400000), "R2", "cke to first precharge",
          cycs[0] - cke_rise, cdiv(400000));
    for (int i = 0; i < 16 && i < n; i++) begin
      chk(pins[i] == exp_pins(i), "R4", $sformatf("pins of cmd %0d", i),
          int'(pins[i]), int'(exp_pins(i)));
      chk(bas[i] == exp_ba(i), tag(i), $sformatf("bank of cmd %0d", i),
          int'(bas[i]), int'(exp_ba(i)));
      chk(adrs[i] == exp_addr(i), tag(i), $sformatf("address of cmd %0d", i),
          int'(adrs[i]), int'(exp_addr(i)));
      if (i < 15 && i + 1 < n)
        chk(cycs[i+1] - cycs[i] == exp_gap(i), (i >= 11) ? "R9" : "R8",
            $sformatf("gap after cmd %0d", i), cycs[i+1] - cycs[i], exp_gap(i));
    end
    if (n == 16)
      chk(done_rise - cycs[15] == cdiv(25000), "R10", "precharge to complete",
          done_rise - cycs[15], cdiv(25000));
  endtask
endmodule

module ddr2_init_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic clr = 1'b1;
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  logic        a_done, a_cke, a_cs, a_ras, a_cas, a_we;
  logic [2:0]  a_ba;
  logic [13:0] a_ad;
  logic        b_done, b_cke, b_cs, b_ras, b_cas, b_we;
  logic [2:0]  b_ba;
  logic [13:0] b_ad;
  logic        y_done, y_cke, y_cs, y_ras, y_cas, y_we;
  logic [2:0]  y_ba;
  logic [13:0] y_ad;

  ddr2_init_seq #(.SIM_MODE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .init_start_i(start), .init_complete_o(a_done),
    .cke_o(a_cke), .cs_n_o(a_cs), .ras_n_o(a_ras), .cas_n_o(a_cas), .we_n_o(a_we),
    .ba_o(a_ba), .addr_o(a_ad));

  ddr2_init_seq #(.TCK_PS(5000), .CAS_LAT(3), .ADD_LAT(2), .WR_CYC(4), .SEQ_BURST(1'b0),
                  .RTT_OHM(50), .FULL_DRIVE(1'b0), .DIFF_DQS(1'b0), .SIM_MODE(1'b1)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .init_start_i(start), .init_complete_o(b_done),
    .cke_o(b_cke), .cs_n_o(b_cs), .ras_n_o(b_ras), .cas_n_o(b_cas), .we_n_o(b_we),
    .ba_o(b_ba), .addr_o(b_ad));

  ddr2_init_seq #(.SIM_MODE(1'b1), .BYPASS(1'b1)) dut_y_i (
    .clk(clk), .rst_n(rst_n), .init_start_i(start), .init_complete_o(y_done),
    .cke_o(y_cke), .cs_n_o(y_cs), .ras_n_o(y_ras), .cas_n_o(y_cas), .we_n_o(y_we),
    .ba_o(y_ba), .addr_o(y_ad));

  ddr2_init_seq_mon #(.NAME("a")) mon_a (
    .clk(clk), .clr(clr), .cyc(cyc), .cke(a_cke), .cs_n(a_cs), .ras_n(a_ras), .cas_n(a_cas),
    .we_n(a_we), .ba(a_ba), .addr(a_ad), .done(a_done));

  ddr2_init_seq_mon #(.TCK_PS(5000), .CAS_LAT(3), .ADD_LAT(2), .WR_CYC(4), .SEQ_BURST(1'b0),
                      .RTT_OHM(50), .FULL_DRIVE(1'b0), .DIFF_DQS(1'b0), .NAME("b")) mon_b (
    .clk(clk), .clr(clr), .cyc(cyc), .cke(b_cke), .cs_n(b_cs), .ras_n(b_ras), .cas_n(b_cas),
    .we_n(b_we), .ba(b_ba), .addr(b_ad), .done(b_done));

  ddr2_init_seq_mon #(.NAME("y")) mon_y (
    .clk(clk), .clr(clr), .cyc(cyc), .cke(y_cke), .cs_n(y_cs), .ras_n(y_ras), .cas_n(y_cas),
    .we_n(y_we), .ba(y_ba), .addr(y_ad), .done(y_done));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d",
             checks + mon_a.checks + mon_b.checks + mon_y.checks,
             fails + mon_a.fails + mon_b.fails + mon_y.fails);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; clr = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; clr = 1'b0;
  endtask

  task automatic check_reset_state(input string req);
    chk({a_cke, a_cs, a_ras, a_cas, a_we, a_done} == 6'b001110, req, "dut_i reset pins",
        int'({a_cke, a_cs, a_ras, a_cas, a_we, a_done}), 'b001110);
    chk({b_cke, b_cs, b_ras, b_cas, b_we, b_done} == 6'b001110, req, "dut_b_i reset pins",
        int'({b_cke, b_cs, b_ras, b_cas, b_we, b_done}), 'b001110);
    chk({y_cke, y_done} == 2'b00, req, "dut_y_i reset pins", int'({y_cke, y_done}), 0);
  endtask

  // One full bring-up; start is dropped after 'hold' cycles (R11).
  task automatic run_round(input int delay, input int hold);
    int se, cnt;
    repeat (delay) @(negedge clk);
    mon_a.verify_idle();
    mon_y.verify_idle();
    check_reset_state("R1");
    start = 1'b1;
    se = cyc + 1;
    cnt = 0;
    while (!(a_done && b_done && cnt >= hold) && cnt < 4000) begin
      @(negedge clk);
      cnt++;
      if (cnt == hold) start = 1'b0;
    end
    start = 1'b0;
    chk(cnt < 4000, "R10", "completion reached", cnt, 4000);
    repeat (40) @(negedge clk);
    mon_a.verify(se, 1'b0);
    mon_b.verify(se, 1'b0);
    mon_y.verify(se, 1'b1);
    chk(a_done && a_cke, "R10", "complete and cke held", int'({a_done, a_cke}), 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd9137));
    // Directed: reset state (R1, R14).
    repeat (2) @(negedge clk);
    check_reset_state("R14");
    // Random start delays and start-hold lengths; last round holds start past completion.
    for (int r = 0; r < 4; r++) begin
      do_reset();
      run_round($urandom_range(30, 2), (r == 3) ? 700 : $urandom_range(60, 1));
      if (r == 3)
        chk(mon_a.n == 16, "R11", "no restart while start held", mon_a.n, 16);
    end
    // Directed: reset in the middle of the sequence, then a clean bring-up (R14).
    do_reset();
    @(negedge clk);
    start = 1'b1;
    repeat ($urandom_range(150, 20)) @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    #1;
    check_reset_state("R14");
    do_reset();
    run_round(5, 3);
    summary();
    $finish;
  end
endmodule